// File: doc/BRIEF.md
# Interleaved Multithreaded Issue Scheduler

This block sits in front of a barrel-style pipeline that holds many hardware thread contexts. On every clock it chooses at most one context whose next instruction may issue, and it reports that choice one cycle later as an issue strobe plus a thread number. A thread that has just issued has to wait a fixed number of ticks before it can issue again. Because of this spacing, a single thread's pipeline hazards are covered by the other threads. When fewer threads are runnable than the spacing requires, the empty slots stay empty.

Each context also keeps track of one outstanding memory reference. A memory instruction brings a 3-bit count of how many later instructions of the same thread do not depend on its result. The thread may run ahead by that many instructions and then blocks until a completion for its thread number arrives. A second memory instruction also blocks while the first reply is still pending. Selection among the ready contexts rotates and starts just after the most recently issued context, so no ready thread starves.

The scheduler does not fetch instructions. For each context the caller presents the kind of instruction waiting at that context's head (memory or not) and its lookahead count.

Top module: `mt_issue_sched`

## Requirements
- R1: At most one context is chosen per clock, and the choice appears on `issue_valid`/`issue_id` exactly one cycle after the cycle in which it was made.
- R2: Two issues from the same context are at least GAP (default 16) cycles apart, and a context with no other obstacle issues again exactly GAP cycles later.
- R3: Among ready contexts, the one chosen is the first found when searching upward from the index after the last issued context, wrapping at NUM_CTX.
- R4: After a memory instruction with lookahead tag T (3-bit field `ctx_tag[i*3 +: 3]`, memory flag `ctx_is_mem[i]=1`), the context may issue T more non-memory instructions while the reply is pending, then blocks.
- R5: A context whose head instruction is a memory instruction does not issue while an earlier reply for that context is still pending.
- R6: A completion (`cpl_valid=1`, `cpl_id=i`) driven in cycle C unblocks context i for selection in cycle C+1 but not in C, so the resulting issue appears at the outputs in cycle C+2.
- R7: A context with `ctx_valid[i]=0` is never chosen; lowering it clears that context's spacing countdown and its memory tracking, so after re-raising it the context can issue at once.
- R8: After reset no issue is reported, no memory reference is pending, all countdowns are zero and the search starts at context 0.
- R9: With fewer ready contexts than GAP, cycles without a ready context report no issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_valid | input | NUM_CTX | Context i holds a live thread |
| ctx_is_mem | input | NUM_CTX | Head instruction of context i is a memory instruction |
| ctx_tag | input | NUM_CTX*TAG_W | Lookahead count of each context's head instruction, context i at [i*TAG_W +: TAG_W] |
| cpl_valid | input | 1 | A memory reply has returned |
| cpl_id | input | $clog2(NUM_CTX) | Context the reply belongs to |
| issue_valid | output | 1 | An instruction issued (registered) |
| issue_id | output | $clog2(NUM_CTX) | Context that issued (registered) |

## Verification
The hardest condition to reach is a context that sits blocked on its lookahead count with its countdown already expired. That is the only state where the exact cycle in which a completion takes effect can be seen at the ports. The stimulus runs a single context alone so that no other thread masks its slots. It issues a memory instruction with a small tag and then switches the head to non-memory instructions. It waits until the allowance is used up and the spacing has run out, and then sends the reply. Only then can an early or late unblock be seen as a shifted issue strobe.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int SCHED_MAX_CTX   = 128;
    localparam int SCHED_DEF_GAP   = 16;
    localparam int SCHED_DEF_TAG_W = 3;
endpackage

// File: rtl/sched_ctx_tracker.sv
module sched_ctx_tracker #(
    parameter int GAP   = sched_pkg::SCHED_DEF_GAP,
    parameter int TAG_W = sched_pkg::SCHED_DEF_TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             is_mem,
    input  logic [TAG_W-1:0] tag,
    input  logic             grant,
    input  logic             cpl_hit,
    output logic             ready
);
    localparam int CW = (GAP > 2) ? $clog2(GAP) : 1;

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             pend;
        logic [TAG_W-1:0] ahead;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        if (cpl_hit) st_d.pend = 1'b0;
        if (grant) begin
            st_d.cnt = CW'(GAP - 1);
            if (is_mem) begin
                st_d.pend  = 1'b1;
                st_d.ahead = tag;
            end else if (st_q.pend) begin
                st_d.ahead = st_q.ahead - 1'b1;
            end
        end
        if (!en) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = en && (st_q.cnt == '0) &&
                   !(st_q.pend && (is_mem || st_q.ahead == '0));
endmodule

// File: rtl/sched_rr_picker.sv
module sched_rr_picker #(
    parameter int NUM_CTX = 8,
    localparam int IW = $clog2(NUM_CTX)
) (
    input  logic [NUM_CTX-1:0] req,
    input  logic [IW-1:0]      ptr,
    output logic               found,
    output logic [IW-1:0]      sel
);
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < NUM_CTX; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= NUM_CTX) idx = idx - NUM_CTX;
            if (!found && req[idx]) begin
                found = 1'b1;
                sel   = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/mt_issue_sched.sv
module mt_issue_sched #(
    parameter int NUM_CTX = 8,
    parameter int GAP     = sched_pkg::SCHED_DEF_GAP,
    parameter int TAG_W   = sched_pkg::SCHED_DEF_TAG_W,
    localparam int IW = $clog2(NUM_CTX)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CTX-1:0]       ctx_valid,
    input  logic [NUM_CTX-1:0]       ctx_is_mem,
    input  logic [NUM_CTX*TAG_W-1:0] ctx_tag,
    input  logic                     cpl_valid,
    input  logic [IW-1:0]            cpl_id,
    output logic                     issue_valid,
    output logic [IW-1:0]            issue_id
);
    typedef struct packed {
        logic [IW-1:0] ptr;
        logic          ovld;
        logic [IW-1:0] oid;
    } top_t;

    top_t top_d, top_q;

    logic [NUM_CTX-1:0] ready;
    logic               found;
    logic [IW-1:0]      sel;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        sched_ctx_tracker #(.GAP(GAP), .TAG_W(TAG_W)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ctx_valid[g]),
            .is_mem  (ctx_is_mem[g]),
            .tag     (ctx_tag[g*TAG_W +: TAG_W]),
            .grant   (found && (sel == IW'(g))),
            .cpl_hit (cpl_valid && (cpl_id == IW'(g))),
            .ready   (ready[g])
        );
    end

    sched_rr_picker #(.NUM_CTX(NUM_CTX)) u_pick (
        .req   (ready),
        .ptr   (top_q.ptr),
        .found (found),
        .sel   (sel)
    );

    always_comb begin
        top_d      = top_q;
        top_d.ovld = found;
        top_d.oid  = sel;
        if (found) begin
            if (sel == IW'(NUM_CTX - 1)) top_d.ptr = '0;
            else                         top_d.ptr = sel + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign issue_valid = top_q.ovld;
    assign issue_id    = top_q.oid;
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
    parameter int NUM_CTX = 8,
    parameter int GAP     = 16,
    localparam int IW = $clog2(NUM_CTX),
    localparam int SW = $clog2(GAP + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CTX-1:0] ctx_valid,
    input logic               issue_valid,
    input logic [IW-1:0]      issue_id
);
    logic [NUM_CTX-1:0] vld_q;
    logic [SW-1:0]      since_q [NUM_CTX];

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= ctx_valid;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (!rst_n || !ctx_valid[i])
                since_q[i] <= SW'(GAP);
            else if (issue_valid && issue_id == IW'(i))
                since_q[i] <= SW'(1);
            else if (since_q[i] != SW'(GAP))
                since_q[i] <= since_q[i] + 1'b1;
        end
    end

    AST_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> vld_q[issue_id]); // R7
    AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> since_q[issue_id] >= SW'(GAP)); // R2
    AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_valid == '0) |=> !issue_valid); // R9
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !(issue_valid && issue_id == $past(issue_id))); // R1
endmodule

bind mt_issue_sched sched_checker #(.NUM_CTX(NUM_CTX), .GAP(GAP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctx_valid   (ctx_valid),
    .issue_valid (issue_valid),
    .issue_id    (issue_id)
);

// File: tb/mt_issue_sched_test.sv
`timescale 1ns/1ps
module mt_issue_sched_test;
    localparam int N = 8, GAP = 16, TW = 3, IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ctx_valid = '0;
    logic [N-1:0]  ctx_is_mem = '0;
    logic [N*TW-1:0] ctx_tag = '0;
    logic          cpl_valid = 1'b0;
    logic [IW-1:0] cpl_id = '0;
    logic          issue_valid;
    logic [IW-1:0] issue_id;

    always #2.5 clk = ~clk;

    mt_issue_sched #(.NUM_CTX(N), .GAP(GAP), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .ctx_valid(ctx_valid), .ctx_is_mem(ctx_is_mem),
        .ctx_tag(ctx_tag), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
        .issue_valid(issue_valid), .issue_id(issue_id)
    );

    typedef struct { int id; int stamp; string req; } exp_t;
    exp_t  q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    string cur_req = "R8";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(int id, int stamp, string req);
        exp_t e;
        e.id = id; e.stamp = stamp; e.req = req;
        q.push_back(e);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every reported issue
    always @(negedge clk) begin
        if (rst_n && issue_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, cur_req, "unexpected issue id", int'(issue_id), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(int'(issue_id) == e.id, e.req, "issue id", int'(issue_id), e.id);
                chk(cyc == e.stamp, e.req, "issue cycle", cyc, e.stamp);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_to(int c);
        while (cyc < c) tick(1);
    endtask

    task automatic drained(string req);
        chk(q.size() == 0, req, "pending expected issues", q.size(), 0);
    endtask

    task automatic send_cpl(int id);
        cpl_valid = 1'b1; cpl_id = IW'(id);
        tick(1);
        cpl_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL R1: watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int e;
        int c;
        tick(3);
        chk(issue_valid == 1'b0, "R8", "issue_valid in reset", int'(issue_valid), 0);
        rst_n = 1'b1;
        tick(5);
        chk(issue_valid == 1'b0, "R8", "issue_valid after reset", int'(issue_valid), 0);

        // Four plain threads: sweep from 0, then idle until spacing expires
        cur_req = "R9";
        ctx_valid = 8'h0F;
        e = cyc;
        push(0, e + 1, "R8"); push(1, e + 2, "R1"); push(2, e + 3, "R3"); push(3, e + 4, "R3");
        push(0, e + 17, "R2"); push(1, e + 18, "R9"); push(2, e + 19, "R9"); push(3, e + 20, "R2");
        wait_to(e + 20);
        ctx_valid = '0;
        tick(3);
        drained("R2");
        tick(20);

        // Rotation: pointer sits at 4, contexts 1 and 6 ready
        cur_req = "R3";
        ctx_valid = 8'b0100_0010;
        e = cyc;
        push(6, e + 1, "R3"); push(1, e + 2, "R3");
        wait_to(e + 3);
        ctx_valid = '0;
        tick(3);
        drained("R3");
        tick(20);

        // Lookahead: memory op with tag 2, then two independent ops, then blocked
        cur_req = "R4";
        ctx_is_mem[2] = 1'b1; ctx_tag[6 +: 3] = 3'd2;
        ctx_valid = 8'h04;
        e = cyc;
        push(2, e + 1, "R4");
        wait_to(e + 2);
        ctx_is_mem[2] = 1'b0;
        push(2, e + 17, "R4"); push(2, e + 33, "R4");
        wait_to(e + 55);
        drained("R4");
        cur_req = "R6";
        c = cyc;
        push(2, c + 2, "R6");
        send_cpl(2);
        wait_to(c + 2);
        ctx_valid = '0;
        tick(3);
        drained("R6");
        tick(20);

        // Second memory op waits for the first reply
        cur_req = "R5";
        ctx_is_mem[2] = 1'b1; ctx_tag[6 +: 3] = 3'd7;
        ctx_valid = 8'h04;
        e = cyc;
        push(2, e + 1, "R5");
        wait_to(e + 40);
        drained("R5");
        c = cyc;
        push(2, c + 2, "R5");
        send_cpl(2);
        wait_to(c + 2);
        ctx_valid = '0;
        tick(3);
        drained("R5");
        tick(20);

        // Lowering valid clears countdown and pending reference
        cur_req = "R7";
        ctx_is_mem[5] = 1'b1; ctx_tag[15 +: 3] = 3'd0;
        ctx_valid = 8'h20;
        e = cyc;
        push(5, e + 1, "R7");
        wait_to(e + 2);
        ctx_is_mem[5] = 1'b0;
        wait_to(e + 3);
        ctx_valid = '0;
        tick(1);
        ctx_valid = 8'h20;
        push(5, e + 5, "R7");
        wait_to(e + 8);
        ctx_valid = '0;
        tick(3);
        drained("R7");
        tick(20);
        chk(issue_valid == 1'b0, "R7", "issue_valid with no live context", int'(issue_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule